// File: doc/BRIEF.md
# Frame-Synchronous Symbol Command Queue

This block receives single bytes through a pipelined Wishbone slave port and packs each group of three into a 24-bit symbol command. Each complete command names a screen tile by row and column. It either places a symbol in that tile by storing the symbol's memory address, or clears the tile. Commands are not applied as they arrive. They wait in a 300-entry queue until vertical sync is asserted.

While vertical sync is high, the queue drains at one command per clock into a tile map RAM. The RAM holds one 14-bit entry for each 32x32 tile of a 640x480 screen. That is 15 rows by 20 columns, and the tile at row x, column y sits at entry 20*x + y. A downstream read manager fetches entries through a registered read port. When a vertical-sync period has emptied the queue, the block raises a one-cycle completion strobe so the reader knows the map is consistent for the next frame.

Top module: `symq_top`

## Requirements
- R1: A command arrives as three bytes, most significant byte first. Command bit 23 is the kind (1 = place, 0 = clear), bits 22:19 the tile row, bits 18:14 the tile column, and bits 13:0 the symbol address.
- R2: Every byte taken (cyc and stb high, stall low) is acknowledged with `wb_ack_o` in the following cycle. On the third byte of an in-range command, that command enters the queue and `q_used_o` rises by one.
- R3: If the third byte completes a command whose row exceeds 14 or whose column exceeds 19, the command is discarded. `wb_err_o` replaces `wb_ack_o` for that byte, `q_used_o` does not change, and the next byte starts a new command.
- R4: The queue holds 300 commands. `q_used_o` gives the fill level, and `q_full_o` and `wb_stall_o` are high at 300 entries. While stall is high, no byte is taken and no ack or err is returned.
- R5: While `vsync_i` is low, no queued command is removed and the map contents do not change.
- R6: While `vsync_i` is high and the queue is not empty, one command per cycle leaves the queue in arrival order. A place command writes its symbol address to entry 20*row + column.
- R7: A clear command writes zero to its entry, whatever its address field holds.
- R8: A read with `map_rd_en_i` high returns the entry in `map_rd_data_o`, with `map_rd_valid_o` high, exactly one cycle later. Addresses 300 and above read as zero.
- R9: `map_done_o` pulses for exactly one cycle in the cycle after the first cycle of a vertical-sync period in which the queue is empty. It pulses at most once per period, and a period starting with N queued commands yields the pulse N+1 cycles after vsync rises.
- R10: After reset the queue is empty, `q_used_o` is 0, every map entry reads zero, and ack, err, read-valid and done are all low.
- R11: `wb_adr_i` and `wb_tga_i` have no effect; the byte's position within a command is set only by arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Byte strobe |
| wb_adr_i | input | 10 | Bus address (not used) |
| wb_tga_i | input | 10 | Bus tag (not used) |
| wb_dat_i | input | 8 | Command byte |
| wb_ack_o | output | 1 | Byte accepted, one cycle after taking it |
| wb_err_o | output | 1 | Command rejected as out of range |
| wb_stall_o | output | 1 | Queue full, byte not taken |
| vsync_i | input | 1 | Vertical sync; drain window |
| map_rd_en_i | input | 1 | Map read request |
| map_rd_addr_i | input | 9 | Map read entry index |
| map_rd_data_o | output | 14 | Map read data |
| map_rd_valid_o | output | 1 | Read data valid |
| q_empty_o | output | 1 | Queue empty |
| q_full_o | output | 1 | Queue full |
| q_used_o | output | 9 | Commands in queue |
| map_done_o | output | 1 | Map update complete strobe |

## Verification
The assertions check the following on every cycle:
- the fill level never exceeds 300;
- ack and err are never high together, and neither appears without a byte taken one cycle earlier or after a stalled cycle;
- the fill level never falls outside vertical sync;
- the read-valid flag follows the read enable by one cycle;
- the completion strobe lasts a single cycle and follows an empty queue seen during vertical sync.

Only the bench's scenarios can show the end-to-end results:
- byte order and field layout;
- the 20*x + y placement and the zero written by a clear;
- rejection and realignment after an out-of-range command;
- stall behaviour at 300 entries;
- the exact cycle of the completion strobe.

// File: rtl/symq_pkg.sv
package symq_pkg;
    localparam int TILE_ROWS = 15;
    localparam int TILE_COLS = 20;
    localparam int TILES     = TILE_ROWS * TILE_COLS;
    localparam int SYM_W     = 14;
    localparam int MAP_AW    = $clog2(TILES);
    localparam int CMD_W     = 24;

    typedef struct packed {
        logic             place;
        logic [3:0]       row;
        logic [4:0]       col;
        logic [SYM_W-1:0] sym;
    } sym_cmd_t;

    typedef enum logic [1:0] {
        GET_HI  = 2'd0,
        GET_MID = 2'd1,
        GET_LO  = 2'd2
    } asm_state_e;
endpackage

// File: rtl/symq_byte_collect.sv
module symq_byte_collect
    import symq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cyc_i,
    input  logic     stb_i,
    input  logic [7:0] dat_i,
    input  logic     full_i,
    output logic     ack_o,
    output logic     err_o,
    output logic     push_o,
    output sym_cmd_t cmd_o
);
    typedef struct packed {
        asm_state_e st;
        logic [7:0] hi;
        logic [7:0] mid;
        logic       ack;
        logic       err;
    } col_reg_t;

    col_reg_t r_q, r_d;
    logic     take;
    logic     in_range;

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        r_d.err  = 1'b0;
        push_o   = 1'b0;
        take     = cyc_i && stb_i && !full_i;
        cmd_o    = sym_cmd_t'({r_q.hi, r_q.mid, dat_i});
        in_range = (int'(cmd_o.row) < TILE_ROWS) && (int'(cmd_o.col) < TILE_COLS);
        if (take) begin
            unique case (r_q.st)
                GET_HI: begin
                    r_d.hi  = dat_i;
                    r_d.st  = GET_MID;
                    r_d.ack = 1'b1;
                end
                GET_MID: begin
                    r_d.mid = dat_i;
                    r_d.st  = GET_LO;
                    r_d.ack = 1'b1;
                end
                default: begin
                    r_d.st  = GET_HI;
                    push_o  = in_range;
                    r_d.ack = in_range;
                    r_d.err = !in_range;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: GET_HI, hi: '0, mid: '0, ack: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o = r_q.ack;
    assign err_o = r_q.err;
endmodule

// File: rtl/symq_cmd_fifo.sv
module symq_cmd_fifo #(
    parameter  int DEPTH = 300,
    parameter  int WIDTH = 24,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CNT_W-1:0] used_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_reg_t;

    fifo_reg_t        r_q, r_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_push, do_pop;

    always_comb begin
        r_d     = r_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            r_d.wr = (r_q.wr == PTR_W'(DEPTH - 1)) ? '0 : r_q.wr + 1'b1;
        end
        if (do_pop) begin
            r_d.rd = (r_q.rd == PTR_W'(DEPTH - 1)) ? '0 : r_q.rd + 1'b1;
        end
        r_d.cnt = r_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[r_q.wr] <= data_i;
        end
    end

    assign head_o  = mem[r_q.rd];
    assign empty_o = (r_q.cnt == '0);
    assign full_o  = (r_q.cnt == CNT_W'(DEPTH));
    assign used_o  = r_q.cnt;
endmodule

// File: rtl/symq_drain.sv
module symq_drain
    import symq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              empty_i,
    input  sym_cmd_t          head_i,
    output logic              pop_o,
    output logic              wr_en_o,
    output logic [MAP_AW-1:0] wr_addr_o,
    output logic [SYM_W-1:0]  wr_data_o,
    output logic              done_o
);
    typedef struct packed {
        logic armed;
        logic done;
    } drn_reg_t;

    drn_reg_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        pop_o     = vsync_i && !empty_i;
        wr_en_o   = pop_o;
        wr_addr_o = MAP_AW'(head_i.row) * MAP_AW'(TILE_COLS) + MAP_AW'(head_i.col);
        wr_data_o = head_i.place ? head_i.sym : '0;
        r_d.done  = vsync_i && empty_i && r_q.armed;
        if (!vsync_i) begin
            r_d.armed = 1'b1;
        end else if (r_d.done) begin
            r_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
endmodule

// File: rtl/symq_tile_map.sv
module symq_tile_map
    import symq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [MAP_AW-1:0] wr_addr_i,
    input  logic [SYM_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    input  logic [MAP_AW-1:0] rd_addr_i,
    output logic [SYM_W-1:0]  rd_data_o,
    output logic              rd_valid_o
);
    typedef struct packed {
        logic [SYM_W-1:0] data;
        logic             valid;
    } rd_reg_t;

    rd_reg_t          r_q, r_d;
    logic [SYM_W-1:0] mem [TILES];

    always_comb begin
        r_d       = r_q;
        r_d.valid = rd_en_i;
        if (rd_en_i) begin
            r_d.data = (int'(rd_addr_i) < TILES) ? mem[rd_addr_i] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TILES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en_i && (int'(wr_addr_i) < TILES)) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o  = r_q.data;
    assign rd_valid_o = r_q.valid;
endmodule

// File: rtl/symq_top.sv
module symq_top
    import symq_pkg::*;
#(
    parameter  int DEPTH = 300,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic [9:0]        wb_adr_i,
    input  logic [9:0]        wb_tga_i,
    input  logic [7:0]        wb_dat_i,
    output logic              wb_ack_o,
    output logic              wb_err_o,
    output logic              wb_stall_o,
    input  logic              vsync_i,
    input  logic              map_rd_en_i,
    input  logic [MAP_AW-1:0] map_rd_addr_i,
    output logic [SYM_W-1:0]  map_rd_data_o,
    output logic              map_rd_valid_o,
    output logic              q_empty_o,
    output logic              q_full_o,
    output logic [CNT_W-1:0]  q_used_o,
    output logic              map_done_o
);
    sym_cmd_t          new_cmd, head_cmd;
    logic [CMD_W-1:0]  head_raw;
    logic              push, pop;
    logic              map_we;
    logic [MAP_AW-1:0] map_wa;
    logic [SYM_W-1:0]  map_wd;
    logic              unused_bus_fields;

    assign unused_bus_fields = ^{wb_adr_i, wb_tga_i};
    assign wb_stall_o        = q_full_o;
    assign head_cmd          = sym_cmd_t'(head_raw);

    symq_byte_collect u_collect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_i  (wb_cyc_i),
        .stb_i  (wb_stb_i),
        .dat_i  (wb_dat_i),
        .full_i (q_full_o),
        .ack_o  (wb_ack_o),
        .err_o  (wb_err_o),
        .push_o (push),
        .cmd_o  (new_cmd)
    );

    symq_cmd_fifo #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (new_cmd),
        .pop_i   (pop),
        .head_o  (head_raw),
        .empty_o (q_empty_o),
        .full_o  (q_full_o),
        .used_o  (q_used_o)
    );

    symq_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_i   (vsync_i),
        .empty_i   (q_empty_o),
        .head_i    (head_cmd),
        .pop_o     (pop),
        .wr_en_o   (map_we),
        .wr_addr_o (map_wa),
        .wr_data_o (map_wd),
        .done_o    (map_done_o)
    );

    symq_tile_map u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (map_we),
        .wr_addr_i  (map_wa),
        .wr_data_i  (map_wd),
        .rd_en_i    (map_rd_en_i),
        .rd_addr_i  (map_rd_addr_i),
        .rd_data_o  (map_rd_data_o),
        .rd_valid_o (map_rd_valid_o)
    );
endmodule

// File: rtl/symq_checker.sv
module symq_checker #(
    parameter  int DEPTH = 300,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_cyc_i,
    input logic             wb_stb_i,
    input logic             wb_ack_o,
    input logic             wb_err_o,
    input logic             wb_stall_o,
    input logic             vsync_i,
    input logic             map_rd_en_i,
    input logic             map_rd_valid_o,
    input logic             q_empty_o,
    input logic [CNT_W-1:0] q_used_o,
    input logic             map_done_o
);
    a_r4_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_used_o) <= DEPTH);

    a_r3_ack_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_ack_o && wb_err_o));

    a_r2_reply_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_ack_o || wb_err_o) |-> $past(wb_cyc_i && wb_stb_i && !wb_stall_o));

    a_r4_stall_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stall_o |=> !(wb_ack_o || wb_err_o));

    a_r5_no_drain_outside_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_i |=> q_used_o >= $past(q_used_o));

    a_r8_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_en_i |=> map_rd_valid_o);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !map_rd_en_i |=> !map_rd_valid_o);

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        map_done_o |=> !map_done_o);

    a_r9_done_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
        map_done_o |-> ($past(vsync_i) && $past(q_empty_o)));
endmodule

bind symq_top symq_checker #(.DEPTH(DEPTH)) u_symq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wb_cyc_i       (wb_cyc_i),
    .wb_stb_i       (wb_stb_i),
    .wb_ack_o       (wb_ack_o),
    .wb_err_o       (wb_err_o),
    .wb_stall_o     (wb_stall_o),
    .vsync_i        (vsync_i),
    .map_rd_en_i    (map_rd_en_i),
    .map_rd_valid_o (map_rd_valid_o),
    .q_empty_o      (q_empty_o),
    .q_used_o       (q_used_o),
    .map_done_o     (map_done_o)
);

// File: tb/symq_top_tb_top.sv
`timescale 1ns/1ps
module symq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0;
    logic [9:0]  adr = '0, tga = '0;
    logic [7:0]  dat = '0;
    logic        ack, err, stall;
    logic        vsync = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [13:0] rd_data;
    logic        rd_valid;
    logic        empty, full;
    logic [8:0]  used;
    logic        done;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    symq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_adr_i(adr), .wb_tga_i(tga), .wb_dat_i(dat),
        .wb_ack_o(ack), .wb_err_o(err), .wb_stall_o(stall),
        .vsync_i(vsync),
        .map_rd_en_i(rd_en), .map_rd_addr_i(rd_addr),
        .map_rd_data_o(rd_data), .map_rd_valid_o(rd_valid),
        .q_empty_o(empty), .q_full_o(full), .q_used_o(used),
        .map_done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic got_ack, output logic got_err);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; dat = b;
        adr = {2'b10, b}; tga = ~{2'b01, b};  // R11: varying, must not matter
        while (stall) @(negedge clk);
        @(posedge clk); #1;
        got_ack = ack; got_err = err;
        cyc = 1'b0; stb = 1'b0;
    endtask

    task automatic send_cmd(input logic place, input int row, input int col,
                            input logic [13:0] sym, output logic a3, output logic e3);
        logic [23:0] c;
        logic a, e;
        c = {place, 4'(row), 5'(col), sym};
        send_byte(c[23:16], a, e);
        chk(a && !e, "R2 byte1 ack", int'(a), 1);
        send_byte(c[15:8], a, e);
        chk(a && !e, "R2 byte2 ack", int'(a), 1);
        send_byte(c[7:0], a3, e3);
    endtask

    task automatic read_map(input int addr, output int val, output logic vld);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 9'(addr);
        @(posedge clk); #1;
        val = int'(rd_data); vld = rd_valid;
        rd_en = 1'b0;
    endtask

    task automatic drain(input int n, input string req);
        int k = 0, kd = -1;
        bit extra = 0;
        @(negedge clk);
        vsync = 1'b1;
        repeat (n + 6) begin
            @(posedge clk); #1;
            k++;
            if (done) begin
                if (kd < 0) kd = k; else extra = 1;
            end
        end
        chk(kd == n + 1, {req, " R9 done cycle"}, kd, n + 1);
        chk(!extra, "R9 single done per period", int'(extra), 0);
        chk(empty && used == 0, "R6 queue drained", int'(used), 0);
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic t_reset();
        int v; logic vl;
        chk(empty && !full && used == 0, "R10 queue empty", int'(used), 0);
        chk(!ack && !err && !done && !rd_valid, "R10 outputs low",
            int'({ack, err, done, rd_valid}), 0);
        read_map(150, v, vl);
        chk(vl && v == 0, "R10 map zero", v, 0);
    endtask

    task automatic t_place_and_drain();
        logic a, e; int v; logic vl;
        send_cmd(1'b1, 0, 0, 14'h1234, a, e);
        chk(a && !e, "R2 cmd ack", int'(a), 1);
        send_cmd(1'b1, 14, 19, 14'h3FFF, a, e);
        chk(a && !e, "R2 cmd ack", int'(a), 1);
        send_cmd(1'b1, 7, 5, 14'h0ABC, a, e);
        chk(used == 3, "R2 used count", int'(used), 3);
        repeat (10) @(posedge clk);
        #1;
        chk(used == 3, "R5 held while vsync low", int'(used), 3);
        read_map(145, v, vl);
        chk(v == 0, "R5 map unchanged before vsync", v, 0);
        drain(3, "place");
        read_map(0, v, vl);
        chk(v == 'h1234, "R1 R6 entry 0", v, 'h1234);
        read_map(299, v, vl);
        chk(vl && v == 'h3FFF, "R6 R8 entry 299", v, 'h3FFF);
        read_map(145, v, vl);
        chk(v == 'h0ABC, "R6 entry 20*7+5 (R11 adr ignored)", v, 'h0ABC);
    endtask

    task automatic t_clear();
        logic a, e; int v; logic vl;
        send_cmd(1'b0, 7, 5, 14'h1111, a, e);
        chk(a, "R2 clear ack", int'(a), 1);
        drain(1, "clear");
        read_map(145, v, vl);
        chk(v == 0, "R7 clear writes zero", v, 0);
        read_map(0, v, vl);
        chk(v == 'h1234, "R7 other entry kept", v, 'h1234);
    endtask

    task automatic t_bad_range();
        logic a, e; int v; logic vl;
        send_cmd(1'b1, 15, 0, 14'h0001, a, e);
        chk(e && !a, "R3 row 15 err", int'(e), 1);
        chk(used == 0, "R3 not queued", int'(used), 0);
        send_cmd(1'b1, 0, 20, 14'h0002, a, e);
        chk(e && !a, "R3 col 20 err", int'(e), 1);
        send_cmd(1'b1, 3, 4, 14'h0055, a, e);
        chk(a && !e && used == 1, "R3 realigned after err", int'(used), 1);
        drain(1, "after-err");
        read_map(64, v, vl);
        chk(v == 'h55, "R3 good cmd applied", v, 'h55);
    endtask

    task automatic t_full();
        logic a, e; bit saw = 0; int v; logic vl;
        for (int i = 0; i < 300; i++) begin
            send_cmd(1'b1, i / 20, i % 20, 14'(i + 1), a, e);
        end
        #1;
        chk(full && stall && used == 300, "R4 full at 300", int'(used), 300);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; dat = 8'hAA;
        repeat (4) begin
            @(posedge clk); #1;
            if (ack || err) saw = 1;
        end
        cyc = 1'b0; stb = 1'b0;
        chk(!saw && used == 300, "R4 stalled byte not taken", int'(saw), 0);
        drain(300, "full");
        read_map(1, v, vl);
        chk(v == 2, "R6 order entry 1", v, 2);
        read_map(299, v, vl);
        chk(v == 300, "R6 last entry", v, 300);
        read_map(300, v, vl);
        chk(vl && v == 0, "R8 out-of-range read zero", v, 0);
        read_map(511, v, vl);
        chk(v == 0, "R8 read 511 zero", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_place_and_drain();
        t_clear();
        t_bad_range();
        t_full();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule